// File: doc/BRIEF.md
# Carry-Skip Binary Adder

This block adds two unsigned operands of a parameterized width together with a carry-in. It returns the truncated sum and a carry-out. The operand width is cut into equal groups of bits. Inside each group the carry moves from bit to bit through a chain of full-adder cells.

Each group also forms a single "all bits propagate" flag. When that flag is set, the group cannot alter an incoming carry. A bypass multiplexer then hands the group's carry-in directly to its carry-out, so the ripple inside the group is not waited on. A long carry therefore crosses whole groups in one step each.

The block is purely combinational. Subtraction is obtained by inverting one operand and setting the carry-in. The width must be a whole multiple of the group size, and elaboration stops with an error otherwise.

Top module: `carry_skip_adder`

## Requirements
- R1: `sum` equals (`a` + `b` + `cin`) modulo 2^W for every operand pair and carry-in.
- R2: `cout` equals bit W of the full-width result `a` + `b` + `cin`.
- R3: Per bit, propagate is `a[i]` XOR `b[i]` and generate is `a[i]` AND `b[i]`. When no bit generates and `cin` is 0, `sum` equals `a` XOR `b` and `cout` is 0.
- R4: When every bit of a group propagates, the group's carry-out equals its carry-in. A carry generated below such a group reaches the group above it unchanged.
- R5: When a group has at least one non-propagating bit, its carry-out equals the arithmetic carry of that group's slice of `a` and `b` plus its carry-in. A carry that rises inside the group through ripple must land on the correct bits.
- R6: When every bit of the whole word propagates, `cout` equals `cin`. In that case `sum` is all ones for `cin` = 0 and all zeros for `cin` = 1.
- R7: A carry generated in the lowest bit travels through every group up to `cout` (for example all-ones plus one gives `sum` = 0 and `cout` = 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Sum, truncated to W bits |
| cout | output | 1 | Carry out of bit W-1 |

## Verification
The bench builds two instances side by side. The first uses W = 16 with groups of 4, giving four groups. That is enough to place a generating group below a fully propagating one and watch the carry skip into the group above. The second uses W = 9 with groups of 3, an odd width and group size. There a group boundary falls in the middle of a nibble, which catches slicing errors that a power-of-two layout would hide. Both instances see the same directed patterns and random operands.

// File: rtl/carry_skip_adder.sv
module carry_skip_adder #(
  parameter int W = 32,
  parameter int M = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int NG = W / M;

  if (W % M != 0) begin : g_bad_size
    $error("carry_skip_adder: W must be a multiple of M");
  end

  logic [W-1:0]  p, g;
  logic [W-1:0]  c;
  logic [NG:0]   sc;
  logic [NG-1:0] gp;

  assign p     = a ^ b;
  assign g     = a & b;
  assign sc[0] = cin;

  for (genvar s = 0; s < NG; s++) begin : g_grp
    logic [M:0] rc;
    assign rc[0] = sc[s];
    for (genvar j = 0; j < M; j++) begin : g_bit
      assign rc[j+1]   = g[s*M+j] | (p[s*M+j] & rc[j]);
      assign c[s*M+j]  = rc[j];
    end
    assign gp[s]   = &p[s*M +: M];
    assign sc[s+1] = gp[s] ? sc[s] : rc[M];
  end

  assign sum  = p ^ c;
  assign cout = sc[NG];
endmodule

// File: rtl/carry_skip_adder_chk.sv
module carry_skip_adder_chk #(
  parameter int W = 32,
  parameter int M = 4
) (
  input logic [W-1:0]   a,
  input logic [W-1:0]   b,
  input logic           cin,
  input logic [W-1:0]   sum,
  input logic           cout,
  input logic [W/M:0]   sc,
  input logic [W/M-1:0] gp
);
  localparam int NG = W / M;

  logic [W:0] ref_full;
  assign ref_full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

  always_comb begin
    // R1
    p_sum_value_r1: assert (sum == ref_full[W-1:0])
      else $error("R1 sum mismatch");
    // R2
    p_carry_out_r2: assert (cout == ref_full[W])
      else $error("R2 cout mismatch");
    // R3
    p_no_generate_r3: assert (!(((a & b) == '0) && !cin) || (sum == (a ^ b) && !cout))
      else $error("R3 sum without generate");
    // R6
    p_full_propagate_r6: assert (((a ^ b) != '1) || (cout == cin))
      else $error("R6 full propagate carry");
  end

  for (genvar s = 0; s < NG; s++) begin : g_chk
    logic [M:0] slice_sum;
    assign slice_sum = {1'b0, a[s*M +: M]} + {1'b0, b[s*M +: M]} + {{M{1'b0}}, sc[s]};
    always_comb begin
      // R4
      p_skip_forward_r4: assert (!gp[s] || (sc[s+1] == sc[s]))
        else $error("R4 skip carry mismatch");
      // R5
      p_ripple_carry_r5: assert (gp[s] || (sc[s+1] == slice_sum[M]))
        else $error("R5 ripple carry mismatch");
    end
  end
endmodule

bind carry_skip_adder carry_skip_adder_chk #(.W(W), .M(M)) u_chk (.*);

// File: tb/tb_carry_skip_adder.sv
`timescale 1ns/1ps
module tb_carry_skip_adder;
  localparam int WA = 16, MA = 4;
  localparam int WB = 9,  MB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [WA-1:0] a_a, b_a, s_a;
  logic          ci_a, co_a;
  logic [WB-1:0] a_b, b_b, s_b;
  logic          ci_b, co_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  carry_skip_adder #(.W(WA), .M(MA)) dut (
    .a(a_a), .b(b_a), .cin(ci_a), .sum(s_a), .cout(co_a));
  carry_skip_adder #(.W(WB), .M(MB)) dut_b (
    .a(a_b), .b(b_b), .cin(ci_b), .sum(s_b), .cout(co_b));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [WA-1:0] x, input logic [WA-1:0] y, input logic ci);
    @(negedge clk);
    a_a = x; b_a = y; ci_a = ci;
    a_b = x[WB-1:0]; b_b = y[WB-1:0]; ci_b = ci;
    #1;
  endtask

  task automatic check_both(input string req);
    logic [WA:0] ea;
    logic [WB:0] eb;
    ea = {1'b0, a_a} + {1'b0, b_a} + {{WA{1'b0}}, ci_a};
    eb = {1'b0, a_b} + {1'b0, b_b} + {{WB{1'b0}}, ci_b};
    chk({req, " R1 wide sum"}, 32'(s_a), 32'(ea[WA-1:0]));
    chk({req, " R2 wide cout"}, 32'(co_a), 32'(ea[WA]));
    chk({req, " R1 odd sum"}, 32'(s_b), 32'(eb[WB-1:0]));
    chk({req, " R2 odd cout"}, 32'(co_b), 32'(eb[WB]));
  endtask

  task automatic t_zero_state;
    drive('0, '0, 1'b0);
    chk("R1 zero inputs sum", 32'(s_a), 32'h0);
    chk("R2 zero inputs cout", 32'(co_a), 32'h0);
  endtask

  task automatic t_no_generate_r3;
    drive(16'hA5A5, 16'h5050, 1'b0);
    chk("R3 sum is xor", 32'(s_a), 32'hF5F5);
    chk("R3 cout zero", 32'(co_a), 32'h0);
    check_both("R3");
  endtask

  task automatic t_skip_group_r4;
    // group0 generates a carry, group1 all propagates, group2 receives it
    drive(16'h00AF, 16'h0051, 1'b0);
    chk("R4 skipped carry lands in group2", 32'(s_a), 32'h0100);
    check_both("R4");
    // two propagating groups in a row above a generating one
    drive(16'h0A5F, 16'h05A1, 1'b0);
    chk("R4 double skip", 32'(s_a), 32'h1000);
    check_both("R4");
  endtask

  task automatic t_ripple_r5;
    drive(16'h0007, 16'h0001, 1'b0);
    chk("R5 ripple inside group", 32'(s_a), 32'h0008);
    drive(16'h0036, 16'h000B, 1'b1);
    check_both("R5");
  endtask

  task automatic t_all_propagate_r6;
    drive(16'hF0F0, 16'h0F0F, 1'b0);
    chk("R6 sum all ones", 32'(s_a), 32'hFFFF);
    chk("R6 cout follows cin 0", 32'(co_a), 32'h0);
    chk("R6 odd sum all ones", 32'(s_b), 32'h1FF);
    drive(16'hF0F0, 16'h0F0F, 1'b1);
    chk("R6 sum zero", 32'(s_a), 32'h0000);
    chk("R6 cout follows cin 1", 32'(co_a), 32'h1);
    chk("R6 odd cout", 32'(co_b), 32'h1);
  endtask

  task automatic t_full_chain_r7;
    drive(16'hFFFF, 16'h0001, 1'b0);
    chk("R7 chain sum", 32'(s_a), 32'h0000);
    chk("R7 chain cout", 32'(co_a), 32'h1);
    chk("R7 odd chain sum", 32'(s_b), 32'h000);
    chk("R7 odd chain cout", 32'(co_b), 32'h1);
    drive(16'hFFFF, 16'hFFFF, 1'b1);
    check_both("R7");
  endtask

  task automatic t_random;
    for (int k = 0; k < 300; k++) begin
      drive(16'($urandom), 16'($urandom), 1'($urandom));
      check_both("random");
    end
  endtask

  initial begin
    a_a = '0; b_a = '0; ci_a = 1'b0;
    a_b = '0; b_b = '0; ci_b = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_zero_state();
    t_no_generate_r3();
    t_skip_group_r4();
    t_ripple_r5();
    t_all_propagate_r6();
    t_full_chain_r7();
    t_random();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule